// File: doc/BRIEF.md
# Addressed Receive Pipe Endpoint

This block is one receive channel among many that hang off a single host-to-fabric bridge. The bridge broadcasts a 19-bit downstream word to every channel each clock. A channel that sees its own 7-bit address, with the direction flag set for host-to-fabric traffic, takes in the byte carried by that word. It then hands the bytes to user logic in order, one per clock, with a request strobe and a registered data bus. The 7-bit address space allows up to 128 such channels on one bridge.

User logic may raise a pause input at any time, including before any byte has arrived. Delivery stops while pause is high. Incoming bytes collect in a small internal buffer. When the buffer is about to run out of room, the channel raises a stall flag in its 10-bit upstream word. The bridge ORs the upstream words of all channels bit by bit. For that reason a channel that is not being addressed drives all zeros upstream, so it can never mask or fake another channel's flags.

Top module: `rxpipe_endpoint`

## Requirements
- R1: During synchronous active-low reset, and in the first cycle after it, the request output is low, the data output is zero and the upstream word is zero.
- R2: Downstream field layout: bits [6:0] target address, [14:7] data byte, [15] byte-valid, [16] direction (1 = host to fabric), [17] end marker, [18] spare. A byte is accepted at a clock edge only when the target address equals the address input, direction is 1 and byte-valid is 1.
- R3: After any edge where the downstream word does not target this pipe with direction 1, the upstream word is all zeros, and beats that are not accepted are never delivered.
- R4: Accepted bytes come out in arrival order, at most one per clock. The data output is valid in each cycle the request output is high. A byte accepted into an empty, unpaused pipe at edge k is presented after edge k+1.
- R5: If pause is high at an edge, the request output is low during the following cycle. No byte is lost or duplicated across a pause.
- R6: Pause raised before a transfer begins blocks all delivery while it stays high. Up to DEPTH bytes are held meanwhile.
- R7: Upstream layout: bit 0 stall, bit 1 selected, bits [9:2] zero. After an edge where the pipe is targeted with direction 1, bit 1 is 1 and bit 0 is 1 exactly when the buffer then holds DEPTH bytes.
- R8: If the bridge sends no byte in any cycle that follows a stall flag of 1, every byte the bridge sends is delivered exactly once. The buffer never holds more than DEPTH bytes.
- R9: The end marker and spare bits have no effect on acceptance or delivery.
- R10: Buffered bytes keep draining to user logic after the bridge moves on to another address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_addr | input | 7 | This pipe's address |
| bus_dn | input | 19 | Broadcast word from the bridge |
| pause | input | 1 | User hold-off for delivery |
| rd_req | output | 1 | A byte is on rd_data this cycle |
| rd_data | output | 8 | Delivered byte |
| up_word | output | 10 | Upstream flags, ORed with other pipes |

## Verification
Two instances sit on one shared bus at different addresses, and their upstream words are ORed. The bench sends traffic to one pipe and checks that the other stays silent. A pipe that ignored the address or the direction flag would deliver bytes nobody expected, and a pipe that drove nonzero upstream while unselected would stall the bridge for the wrong channel. Pause is raised before a burst and toggled in the middle of one. A design that lost the byte in flight, or that stalled one edge too late, would drop or duplicate a byte in the scoreboard. Other cases covered: a full buffer while paused, a channel that keeps draining after deselection, and beats with the end and spare bits set.

// File: rtl/rxpipe_pkg.sv
// Shared field layout of the downstream and upstream words.
// Assumes: one bridge owns the downstream bus; upstream words are ORed.
package rxpipe_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int DN_W   = 19;
    localparam int UP_W   = 10;

    // Downstream beat, MSB first: spare, end, dir, valid, data, addr.
    typedef struct packed {
        logic              spare;
        logic              last;
        logic              dir;
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } dn_beat_t;

    // Upstream word: reserved zeros, selected flag, stall flag.
    typedef struct packed {
        logic [UP_W-3:0] rsvd;
        logic            sel;
        logic            stall;
    } up_word_t;
endpackage

// File: rtl/rxpipe_decode.sv
// Address and direction match on the broadcast word.
// Assumes: direction 1 means host to fabric; end and spare bits unused here.
module rxpipe_decode
    import rxpipe_pkg::*;
(
    input  logic [DN_W-1:0]   bus_dn,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              hit,
    output logic              take,
    output logic [BYTE_W-1:0] take_data
);
    dn_beat_t beat;

    // Split the broadcast word and decide whether it is ours.
    always_comb begin
        beat      = dn_beat_t'(bus_dn);
        hit       = (beat.addr == my_addr) && beat.dir;
        take      = hit && beat.valid;
        take_data = beat.data;
    end
endmodule

// File: rtl/rxpipe_fifo.sv
// Circular byte buffer that absorbs beats while delivery is held off.
// Assumes: a push when full with no pop is dropped (bridge must honour stall).
module rxpipe_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_nxt
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    // Qualify requests against the current fill level.
    always_comb begin
        empty     = (level == '0);
        pop_ok    = pop && !empty;
        push_ok   = push && ((level != LVL_W'(DEPTH)) || pop_ok);
        level_nxt = level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        head      = mem[rd_ptr];
    end

    // Advance pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            level <= level_nxt;
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Write storage; one slot per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == PTR_W'(g)))
                mem[g] <= wdata;
        end
    end
endmodule

// File: rtl/rxpipe_deliver.sv
// Registered output stage: one byte per clock to user logic unless paused.
// Assumes: user logic takes every byte presented with the request high.
module rxpipe_deliver #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pause,
    input  logic         avail,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic         rd_req,
    output logic [W-1:0] rd_data
);
    // Pop the buffer head whenever data waits and the user allows it.
    always_comb pop = avail && !pause;

    // Register the strobe and the byte handed to the user.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_req <= pop;
            if (pop)
                rd_data <= head;
        end
    end
endmodule

// File: rtl/rxpipe_uplink.sv
// Builds the OR-safe upstream word: zero unless this pipe is targeted.
// Assumes: bridge reacts to the stall flag in the cycle after it appears.
module rxpipe_uplink
    import rxpipe_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [LVL_W-1:0] level_nxt,
    output logic [UP_W-1:0]  up_word
);
    up_word_t up_q;

    // Register the flags for the level reached at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= '0;
        end else begin
            up_q       <= '0;
            up_q.sel   <= hit;
            up_q.stall <= hit && (level_nxt == LVL_W'(DEPTH));
        end
    end

    // Drive the port from the packed word.
    always_comb up_word = up_q;
endmodule

// File: rtl/rxpipe_endpoint.sv
// One addressed receive pipe on the shared bridge bus.
// Assumes: single clock domain; upstream words of all pipes are ORed.
module rxpipe_endpoint
    import rxpipe_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [DN_W-1:0]   bus_dn,
    input  logic              pause,
    output logic              rd_req,
    output logic [BYTE_W-1:0] rd_data,
    output logic [UP_W-1:0]   up_word
);
    logic              hit, take, pop, empty;
    logic [BYTE_W-1:0] take_data, head;
    logic [LVL_W-1:0]  fill_lvl, fill_nxt;

    rxpipe_decode u_decode (
        .bus_dn    (bus_dn),
        .my_addr   (my_addr),
        .hit       (hit),
        .take      (take),
        .take_data (take_data)
    );

    rxpipe_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .wdata     (take_data),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .level     (fill_lvl),
        .level_nxt (fill_nxt)
    );

    rxpipe_deliver #(.W(BYTE_W)) u_deliver (
        .clk     (clk),
        .rst_n   (rst_n),
        .pause   (pause),
        .avail   (!empty),
        .head    (head),
        .pop     (pop),
        .rd_req  (rd_req),
        .rd_data (rd_data)
    );

    rxpipe_uplink #(.DEPTH(DEPTH)) u_uplink (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .level_nxt (fill_nxt),
        .up_word   (up_word)
    );
endmodule

// File: rtl/rxpipe_endpoint_chk.sv
// Property checker for rxpipe_endpoint, attached by bind.
module rxpipe_endpoint_chk
    import rxpipe_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] my_addr,
    input logic [DN_W-1:0]   bus_dn,
    input logic              pause,
    input logic              rd_req,
    input logic [BYTE_W-1:0] rd_data,
    input logic [UP_W-1:0]   up_word,
    input logic [LVL_W-1:0]  fill_lvl
);
    logic aimed;
    always_comb aimed = (bus_dn[ADDR_W-1:0] == my_addr) && bus_dn[16];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rd_req && rd_data == '0 && up_word == '0));

    assert_foreign_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !aimed |=> (up_word == '0));

    assert_req_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ($past(fill_lvl) != '0));

    assert_pause_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !$past(pause));

    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up_word[UP_W-1:2] == '0);

    assert_stall_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up_word[0] |-> up_word[1]);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= LVL_W'(DEPTH));
endmodule

bind rxpipe_endpoint rxpipe_endpoint_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .my_addr  (my_addr),
    .bus_dn   (bus_dn),
    .pause    (pause),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .up_word  (up_word),
    .fill_lvl (fill_lvl)
);

// File: tb/rxpipe_endpoint_bench.sv
module rxpipe_endpoint_bench;
    localparam int DEPTH = 4;
    localparam logic [6:0] ADDR_A = 7'd5;
    localparam logic [6:0] ADDR_B = 7'd9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [18:0] bus_dn;
    logic        pause_a, pause_b;
    logic        rd_req_a, rd_req_b;
    logic [7:0]  rd_data_a, rd_data_b;
    logic [9:0]  up_a, up_b, up_or;

    int checks = 0;
    int fails  = 0;
    int deliv_a = 0;
    int deliv_b = 0;
    bit done = 1'b0;
    logic [7:0] q_a [$];
    logic [7:0] q_b [$];

    always #2 clk = ~clk;
    assign up_or = up_a | up_b;

    rxpipe_endpoint #(.DEPTH(DEPTH)) u_rxpipe_endpoint (
        .clk(clk), .rst_n(rst_n), .my_addr(ADDR_A), .bus_dn(bus_dn),
        .pause(pause_a), .rd_req(rd_req_a), .rd_data(rd_data_a), .up_word(up_a));

    rxpipe_endpoint #(.DEPTH(DEPTH)) u_rxpipe_endpoint_b (
        .clk(clk), .rst_n(rst_n), .my_addr(ADDR_B), .bus_dn(bus_dn),
        .pause(pause_b), .rd_req(rd_req_b), .rd_data(rd_data_b), .up_word(up_b));

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each delivered byte against the scoreboard queues.
    always @(posedge clk) begin
        logic pa, pb;
        pa = pause_a;
        pb = pause_b;
        #1;
        if (rst_n) begin
            if (rd_req_a) begin
                deliv_a++;
                check(!pa, "R5", 32'(rd_req_a), 32'd0);
                if (q_a.size() == 0) check(1'b0, "R3", 32'(rd_data_a), 32'hx);
                else begin
                    logic [7:0] e;
                    e = q_a.pop_front();
                    check(rd_data_a == e, "R4", 32'(rd_data_a), 32'(e));
                end
            end
            if (rd_req_b) begin
                deliv_b++;
                check(!pb, "R5", 32'(rd_req_b), 32'd0);
                if (q_b.size() == 0) check(1'b0, "R3", 32'(rd_data_b), 32'hx);
                else begin
                    logic [7:0] e;
                    e = q_b.pop_front();
                    check(rd_data_b == e, "R4", 32'(rd_data_b), 32'(e));
                end
            end
        end
    end

    task automatic select_pipe(input logic [6:0] addr, input logic dir);
        @(negedge clk);
        bus_dn = {2'b00, dir, 1'b0, 8'h00, addr};
    endtask

    // Driver: bridge model that honours the ORed stall flag (R8).
    task automatic send_burst(input logic [6:0] addr, input int n,
                              input logic [7:0] base, input bit extra);
        select_pipe(addr, 1'b1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            @(negedge clk);
            while (up_or[0]) begin
                bus_dn = {2'b00, 1'b1, 1'b0, 8'h00, addr};
                @(negedge clk);
            end
            b = base + 8'(i * 7);
            bus_dn = {extra ? 1'b1 : 1'b0, extra ? i[0] : 1'b0, 1'b1, 1'b1, b, addr};
            if (addr == ADDR_A) q_a.push_back(b);
            if (addr == ADDR_B) q_b.push_back(b);
        end
        @(negedge clk);
        bus_dn = {2'b00, 1'b1, 1'b0, 8'h00, addr};
    endtask

    task automatic settle();
        repeat (DEPTH + 6) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int da, db;
        rst_n = 1'b0; bus_dn = '0; pause_a = 1'b0; pause_b = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_req_a == 1'b0 && rd_req_b == 1'b0, "R1", 32'(rd_req_a), 32'd0);
        check(up_or == '0, "R1", 32'(up_or), 32'd0);
        check(rd_data_a == '0, "R1", 32'(rd_data_a), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_req_a == 1'b0 && up_a == '0, "R1", 32'(up_a), 32'd0);

        // R2 R4: plain burst to A
        send_burst(ADDR_A, 6, 8'h10, 1'b0);
        check(up_a == 10'b10 && up_b == '0, "R7", 32'(up_a), 32'h2);
        settle();
        check(q_a.size() == 0 && deliv_a == 6, "R4", 32'(deliv_a), 32'd6);

        // R3: traffic for B leaves A silent
        send_burst(ADDR_B, 5, 8'h40, 1'b0);
        check(up_a == '0, "R3", 32'(up_a), 32'd0);
        settle();
        check(deliv_a == 6 && deliv_b == 5, "R3", 32'(deliv_a), 32'd6);

        // R3 R2: wrong direction beats for A are ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            bus_dn = {2'b00, 1'b0, 1'b1, 8'(8'hA0 + i), ADDR_A};
        end
        @(negedge clk);
        check(up_a == '0, "R3", 32'(up_a), 32'd0);
        bus_dn = '0;
        settle();
        check(deliv_a == 6, "R2", 32'(deliv_a), 32'd6);

        // R4 latency: byte at edge k shows after edge k+1
        select_pipe(ADDR_A, 1'b1);
        @(negedge clk);
        bus_dn = {2'b00, 1'b1, 1'b1, 8'h5A, ADDR_A};
        q_a.push_back(8'h5A);
        @(negedge clk);
        bus_dn = {2'b00, 1'b1, 1'b0, 8'h00, ADDR_A};
        check(rd_req_a == 1'b0, "R4", 32'(rd_req_a), 32'd0);
        @(negedge clk);
        check(rd_req_a == 1'b1 && rd_data_a == 8'h5A, "R4", 32'(rd_data_a), 32'h5A);
        settle();

        // R6 R7: pause before transfer, fill to DEPTH, stall raised
        da = deliv_a;
        pause_a = 1'b1;
        fork
            send_burst(ADDR_A, DEPTH + 3, 8'h61, 1'b0);
            begin
                repeat (20) @(negedge clk);
                check(deliv_a == da, "R6", 32'(deliv_a), 32'(da));
                check(up_or == 10'b11, "R7", 32'(up_or), 32'h3);
                pause_a = 1'b0;
            end
        join
        settle();
        check(q_a.size() == 0 && deliv_a == da + DEPTH + 3, "R8",
              32'(deliv_a - da), 32'(DEPTH + 3));

        // R5 R8: pause toggled through a long burst
        da = deliv_a;
        fork
            send_burst(ADDR_A, 24, 8'h03, 1'b0);
            begin
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    pause_a = (i % 5 == 1) || (i % 7 == 3) || (i > 12 && i < 19);
                end
                pause_a = 1'b0;
            end
        join
        settle();
        check(q_a.size() == 0 && deliv_a == da + 24, "R5", 32'(deliv_a - da), 32'd24);

        // R10: A drains after the bridge moves to B
        da = deliv_a; db = deliv_b;
        pause_a = 1'b1;
        send_burst(ADDR_A, 3, 8'hC0, 1'b0);
        send_burst(ADDR_B, 3, 8'hD0, 1'b0);
        check(up_a == '0 && deliv_a == da, "R10", 32'(up_a), 32'd0);
        pause_a = 1'b0;
        settle();
        check(deliv_a == da + 3 && deliv_b == db + 3, "R10", 32'(deliv_a - da), 32'd3);

        // R9: end and spare bits set on every beat
        da = deliv_a;
        send_burst(ADDR_A, 5, 8'hE1, 1'b1);
        settle();
        check(q_a.size() == 0 && deliv_a == da + 5, "R9", 32'(deliv_a - da), 32'd5);

        check(q_b.size() == 0, "R8", 32'(q_b.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule